// File: doc/BRIEF.md
# Three-Core Power Mode Sequencer

This block decides when a chip with three processor cores may drop into one of two low-power modes, and it drives the clock-enable and power-enable lines of every gated domain while it does so. The gated domains are the processor cluster, the embedded flash, the DMA engine and a row of peripheral slices. Each core reports two things: that it is idle in wait-for-interrupt (WFI), and whether it asks for the deeper of the two modes. The block leaves the low-power modes on wake events from a real-time-clock alarm and from the peripheral slices.

Standby halts only the processor cluster. The flash, the DMA engine, the peripherals and the system clock all keep running. Deep sleep removes clock and power from everything except the peripheral slices marked for retention. The always-on RTC domain is not switched by this block. The sequencer always removes clocks one cycle before it removes power. On the way back it restores power first and re-enables clocks only after a settle delay that software sets.

Top module: `pwr_mode_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, `mode` is 00 and every clock-enable and power-enable output is 1.
- R2: Standby is entered only when all three bits of `core_wfi` are 1. With any bit 0 the block stays in active mode (`mode` = 00, all enables 1).
- R3: Deep sleep is entered when all `core_wfi` bits and all `core_ds_req` bits are 1. When every core is in WFI but at least one `core_ds_req` bit is 0, the block enters standby instead.
- R4: On entry to either low-power mode there is one cycle in which the affected clock enables are 0 and every power enable is still 1. Power enables drop on the next cycle.
- R5: In standby, `cpu_clk_en` = `cpu_pwr_en` = 0 and every flash, DMA and peripheral enable is 1. In deep sleep, the CPU, flash and DMA enables are 0, and peripheral slice i has both of its enables equal to `per_ret[i]`.
- R6: In standby, any `core_wfi` bit going to 0 makes the next clock edge set `mode` = 00 and `cpu_pwr_en` = 1. A wake line (`rtc_wake` or any `per_wake` bit) takes effect on the third edge after it is applied.
- R7: In deep sleep, the block wakes on `rtc_wake` or on `per_wake[i]` with `per_ret[i]` = 1. A `per_wake[i]` with `per_ret[i]` = 0, and any change on `core_wfi` or `core_ds_req`, has no effect.
- R8: On leaving a low-power mode, all power enables are 1 from the first wake cycle. Clock enables return to 1 exactly S cycles later, where S is `settle_cyc` sampled at wake. A value of 0 counts as S = 1.
- R9: If a `core_wfi` bit drops during the clock-gate cycle of either entry, or a `core_ds_req` bit drops during the clock-gate cycle of deep-sleep entry, the block returns to active on the next edge and never lowers a power enable.
- R10: No transition goes directly between standby and deep sleep. Setting `core_ds_req` while in standby leaves `mode` at 01.
- R11: `mode` encodes active as 00, standby as 01 and deep sleep as 10. The value 11 never appears. Entry and wake cycles report 00.
- R12: `rtc_wake` and `per_wake` each pass through two flip-flops before use. While in active mode they have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| core_wfi | input | N_CORES | Per-core wait-for-interrupt indication |
| core_ds_req | input | N_CORES | Per-core deep-sleep request flag |
| rtc_wake | input | 1 | RTC alarm wake event (asynchronous) |
| per_wake | input | N_PER | Per-slice peripheral wake/interrupt event (asynchronous) |
| per_ret | input | N_PER | Slice kept alive and wake-enabled in deep sleep |
| settle_cyc | input | SETTLE_W | Power-to-clock settle delay in cycles (0 acts as 1) |
| mode | output | 2 | Current mode: 00 active, 01 standby, 10 deep sleep |
| cpu_clk_en | output | 1 | Processor cluster clock enable |
| cpu_pwr_en | output | 1 | Processor cluster power enable |
| flash_clk_en | output | 1 | Embedded flash clock enable |
| flash_pwr_en | output | 1 | Embedded flash power enable |
| dma_clk_en | output | 1 | DMA clock enable |
| dma_pwr_en | output | 1 | DMA power enable |
| per_clk_en | output | N_PER | Per-slice peripheral clock enable |
| per_pwr_en | output | N_PER | Per-slice peripheral power enable |

## Verification
Core-flag changes act on the very next edge. Their results (entry to the clock-gate cycle, abort, standby exit) are checked one cycle after the inputs are driven. Wake lines cross a two-stage synchronizer, so their first visible result is due after the third edge, and the bench checks the cycles before that as well to confirm nothing moved early. Clock re-enable is checked S edges after the wake cycle, with the cycles in between checked to still show clocks off. Inputs are driven on the falling edge and outputs are compared on the next falling edge, so each check lands a whole number of registered stages after its stimulus.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [2:0] {
    ST_ACT   = 3'd0,
    ST_SB_CG = 3'd1,
    ST_SB    = 3'd2,
    ST_SB_WK = 3'd3,
    ST_DS_CG = 3'd4,
    ST_DS    = 3'd5,
    ST_DS_WK = 3'd6
  } pm_state_e;

  localparam logic [1:0] MODE_ACT = 2'b00;
  localparam logic [1:0] MODE_SB  = 2'b01;
  localparam logic [1:0] MODE_DS  = 2'b10;

  // Enables shared by every non-retained domain, one set per state
  typedef struct packed {
    logic cpu_clk;
    logic cpu_pwr;
    logic sys_clk;   // flash, DMA, non-retained peripheral slices
    logic sys_pwr;
  } dom_gate_t;

  function automatic logic [1:0] mode_of(pm_state_e s);
    case (s)
      ST_SB:   mode_of = MODE_SB;
      ST_DS:   mode_of = MODE_DS;
      default: mode_of = MODE_ACT;
    endcase
  endfunction

  function automatic dom_gate_t gate_of(pm_state_e s);
    case (s)
      ST_SB_CG, ST_SB_WK: gate_of = '{cpu_clk: 1'b0, cpu_pwr: 1'b1, sys_clk: 1'b1, sys_pwr: 1'b1};
      ST_SB:              gate_of = '{cpu_clk: 1'b0, cpu_pwr: 1'b0, sys_clk: 1'b1, sys_pwr: 1'b1};
      ST_DS_CG, ST_DS_WK: gate_of = '{cpu_clk: 1'b0, cpu_pwr: 1'b1, sys_clk: 1'b0, sys_pwr: 1'b1};
      ST_DS:              gate_of = '{cpu_clk: 1'b0, cpu_pwr: 1'b0, sys_clk: 1'b0, sys_pwr: 1'b0};
      default:            gate_of = '{cpu_clk: 1'b1, cpu_pwr: 1'b1, sys_clk: 1'b1, sys_pwr: 1'b1};
    endcase
  endfunction

endpackage

// File: rtl/pms_rst_sync.sv
module pms_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_sync = stg_q[1];
endmodule

// File: rtl/pms_wake_sync.sv
module pms_wake_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= async_in[i];
        sync_q <= meta_q;
      end
    end
    assign sync_out[i] = sync_q;
  end
endmodule

// File: rtl/pms_seq.sv
module pms_seq
  import pms_pkg::*;
#(
  parameter int N_CORES  = 3,
  parameter int N_PER    = 4,
  parameter int SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_CORES-1:0]  core_wfi,
  input  logic [N_CORES-1:0]  core_ds_req,
  input  logic                rtc_s,
  input  logic [N_PER-1:0]    wake_s,
  input  logic [N_PER-1:0]    per_ret,
  input  logic [SETTLE_W-1:0] settle_cyc,
  output pm_state_e           state
);
  localparam logic [SETTLE_W-1:0] ONE = SETTLE_W'(1);

  pm_state_e           state_q, state_d;
  logic [SETTLE_W-1:0] cnt_q, cnt_d;
  logic                cnt_en;
  logic                all_wfi, all_ds, sb_wake, ds_wake, settle_done;

  assign all_wfi     = &core_wfi;
  assign all_ds      = &core_ds_req;
  assign sb_wake     = !all_wfi || rtc_s || (|wake_s);
  assign ds_wake     = rtc_s || (|(wake_s & per_ret));
  assign settle_done = (cnt_q == ONE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_ACT:   if (all_wfi) state_d = all_ds ? ST_DS_CG : ST_SB_CG;
      ST_SB_CG: state_d = all_wfi ? ST_SB : ST_ACT;
      ST_SB:    if (sb_wake) state_d = ST_SB_WK;
      ST_SB_WK: if (settle_done) state_d = ST_ACT;
      ST_DS_CG: state_d = (all_wfi && all_ds) ? ST_DS : ST_ACT;
      ST_DS:    if (ds_wake) state_d = ST_DS_WK;
      ST_DS_WK: if (settle_done) state_d = ST_ACT;
      default:  state_d = ST_ACT;
    endcase
  end

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if ((state_q == ST_SB && state_d == ST_SB_WK) ||
        (state_q == ST_DS && state_d == ST_DS_WK)) begin
      cnt_en = 1'b1;
      cnt_d  = (settle_cyc == '0) ? ONE : settle_cyc;
    end else if (state_q == ST_SB_WK || state_q == ST_DS_WK) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ACT;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= ONE;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign state = state_q;
endmodule

// File: rtl/pms_gate_map.sv
module pms_gate_map
  import pms_pkg::*;
#(
  parameter int N_PER = 4
) (
  input  pm_state_e        state,
  input  logic [N_PER-1:0] per_ret,
  output logic [1:0]       mode,
  output logic             cpu_clk_en,
  output logic             cpu_pwr_en,
  output logic             flash_clk_en,
  output logic             flash_pwr_en,
  output logic             dma_clk_en,
  output logic             dma_pwr_en,
  output logic [N_PER-1:0] per_clk_en,
  output logic [N_PER-1:0] per_pwr_en
);
  dom_gate_t g;

  assign g            = gate_of(state);
  assign mode         = mode_of(state);
  assign cpu_clk_en   = g.cpu_clk;
  assign cpu_pwr_en   = g.cpu_pwr;
  assign flash_clk_en = g.sys_clk;
  assign flash_pwr_en = g.sys_pwr;
  assign dma_clk_en   = g.sys_clk;
  assign dma_pwr_en   = g.sys_pwr;

  // Retained slices stay clocked and powered in every state
  for (genvar i = 0; i < N_PER; i++) begin : g_slice
    assign per_clk_en[i] = g.sys_clk | per_ret[i];
    assign per_pwr_en[i] = g.sys_pwr | per_ret[i];
  end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pms_pkg::*;
#(
  parameter int N_CORES  = 3,
  parameter int N_PER    = 4,
  parameter int SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_CORES-1:0]  core_wfi,
  input  logic [N_CORES-1:0]  core_ds_req,
  input  logic                rtc_wake,
  input  logic [N_PER-1:0]    per_wake,
  input  logic [N_PER-1:0]    per_ret,
  input  logic [SETTLE_W-1:0] settle_cyc,
  output logic [1:0]          mode,
  output logic                cpu_clk_en,
  output logic                cpu_pwr_en,
  output logic                flash_clk_en,
  output logic                flash_pwr_en,
  output logic                dma_clk_en,
  output logic                dma_pwr_en,
  output logic [N_PER-1:0]    per_clk_en,
  output logic [N_PER-1:0]    per_pwr_en
);
  localparam int WK_W = N_PER + 1;

  logic            rst_n_i;
  logic [WK_W-1:0] wk_s;
  pm_state_e       state;

  pms_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  pms_wake_sync #(.W(WK_W)) u_wsync (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .async_in ({rtc_wake, per_wake}),
    .sync_out (wk_s)
  );

  pms_seq #(.N_CORES(N_CORES), .N_PER(N_PER), .SETTLE_W(SETTLE_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .core_wfi    (core_wfi),
    .core_ds_req (core_ds_req),
    .rtc_s       (wk_s[N_PER]),
    .wake_s      (wk_s[N_PER-1:0]),
    .per_ret     (per_ret),
    .settle_cyc  (settle_cyc),
    .state       (state)
  );

  pms_gate_map #(.N_PER(N_PER)) u_map (
    .state        (state),
    .per_ret      (per_ret),
    .mode         (mode),
    .cpu_clk_en   (cpu_clk_en),
    .cpu_pwr_en   (cpu_pwr_en),
    .flash_clk_en (flash_clk_en),
    .flash_pwr_en (flash_pwr_en),
    .dma_clk_en   (dma_clk_en),
    .dma_pwr_en   (dma_pwr_en),
    .per_clk_en   (per_clk_en),
    .per_pwr_en   (per_pwr_en)
  );
endmodule

// File: rtl/pms_chk.sv
module pms_chk #(
  parameter int N_CORES = 3,
  parameter int N_PER   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_CORES-1:0] core_wfi,
  input logic [N_CORES-1:0] core_ds_req,
  input logic [1:0]         mode,
  input logic               cpu_clk_en,
  input logic               cpu_pwr_en,
  input logic               flash_clk_en,
  input logic               flash_pwr_en,
  input logic               dma_clk_en,
  input logic               dma_pwr_en,
  input logic [N_PER-1:0]   per_clk_en,
  input logic [N_PER-1:0]   per_pwr_en,
  input logic [N_PER-1:0]   per_ret
);
  // R11
  mode_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

  // R2
  sb_entry_all_wfi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && $past(mode) != 2'b01) |-> $past(&core_wfi));

  // R3
  ds_entry_all_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && $past(mode) != 2'b10) |-> $past((&core_wfi) && (&core_ds_req)));

  // R4
  clk_off_before_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_pwr_en) |-> $past(!cpu_clk_en));

  // R4
  flash_clk_before_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_pwr_en) |-> $past(!flash_clk_en));

  // R8
  pwr_before_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> $past(cpu_pwr_en));

  // R5
  sb_domains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (!cpu_pwr_en && !cpu_clk_en && flash_pwr_en && flash_clk_en &&
                         dma_pwr_en && dma_clk_en && (&per_pwr_en) && (&per_clk_en)));

  // R5
  ds_domains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> (!cpu_pwr_en && !flash_pwr_en && !dma_pwr_en &&
                         per_pwr_en == per_ret && per_clk_en == per_ret));

  // R10
  no_sb_to_ds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |=> (mode != 2'b10));

  // R10
  no_ds_to_sb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |=> (mode != 2'b01));

  // R6
  sb_prompt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && !(&core_wfi)) |=> (mode == 2'b00 && cpu_pwr_en));
endmodule

bind pwr_mode_seq pms_chk #(.N_CORES(N_CORES), .N_PER(N_PER)) u_pms_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .core_wfi     (core_wfi),
  .core_ds_req  (core_ds_req),
  .mode         (mode),
  .cpu_clk_en   (cpu_clk_en),
  .cpu_pwr_en   (cpu_pwr_en),
  .flash_clk_en (flash_clk_en),
  .flash_pwr_en (flash_pwr_en),
  .dma_clk_en   (dma_clk_en),
  .dma_pwr_en   (dma_pwr_en),
  .per_clk_en   (per_clk_en),
  .per_pwr_en   (per_pwr_en),
  .per_ret      (per_ret)
);

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;
  localparam logic [3:0] RET = 4'b0101;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] core_wfi, core_ds_req;
  logic       rtc_wake;
  logic [3:0] per_wake, per_ret, settle_cyc;
  logic [1:0] mode;
  logic       cpu_clk_en, cpu_pwr_en, flash_clk_en, flash_pwr_en, dma_clk_en, dma_pwr_en;
  logic [3:0] per_clk_en, per_pwr_en;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pwr_mode_seq uut (
    .clk(clk), .rst_n(rst_n), .core_wfi(core_wfi), .core_ds_req(core_ds_req),
    .rtc_wake(rtc_wake), .per_wake(per_wake), .per_ret(per_ret), .settle_cyc(settle_cyc),
    .mode(mode), .cpu_clk_en(cpu_clk_en), .cpu_pwr_en(cpu_pwr_en),
    .flash_clk_en(flash_clk_en), .flash_pwr_en(flash_pwr_en),
    .dma_clk_en(dma_clk_en), .dma_pwr_en(dma_pwr_en),
    .per_clk_en(per_clk_en), .per_pwr_en(per_pwr_en)
  );

  function automatic logic [15:0] ev(logic [1:0] m, logic cc, logic cp, logic sc, logic sp,
                                     logic [3:0] pc, logic [3:0] pp);
    return {m, cc, cp, sc, sp, sc, sp, pc, pp};
  endfunction

  localparam logic [15:0] E_ACT   = {2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 4'hF};
  localparam logic [15:0] E_SB_CG = {2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 4'hF};
  localparam logic [15:0] E_SB    = {2'b01, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'hF, 4'hF};
  localparam logic [15:0] E_DS_CG = {2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, RET, 4'hF};
  localparam logic [15:0] E_DS    = {2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, RET, RET};

  function automatic logic [15:0] act_vec();
    return {mode, cpu_clk_en, cpu_pwr_en, flash_clk_en, flash_pwr_en,
            dma_clk_en, dma_pwr_en, per_clk_en, per_pwr_en};
  endfunction

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] exp);
    logic [15:0] a;
    a = act_vec();
    n_chk++;
    if (a !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, a, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    core_wfi = 3'b000; core_ds_req = 3'b000; rtc_wake = 1'b0; per_wake = 4'h0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle_inputs(); per_ret = RET; settle_cyc = 4'd3;
    tick(2);
    chk("R1 in reset", E_ACT);
    rst_n = 1'b1;
    tick(1);
    chk("R1 after release", E_ACT);
    tick(3);
    chk("R11 active code 00", E_ACT);
  endtask

  task automatic t_partial_wfi();
    core_wfi = 3'b011;
    for (int k = 0; k < 4; k++) begin
      tick(1); chk("R2 partial wfi 011", E_ACT);
    end
    core_wfi = 3'b110; core_ds_req = 3'b111;
    tick(2); chk("R2 partial wfi 110", E_ACT);
    idle_inputs(); tick(1);
  endtask

  // Standby via WFI, exit by WFI drop; settle S cycles of clocks off
  task automatic t_standby(logic [3:0] s);
    settle_cyc = s;
    core_wfi = 3'b111; core_ds_req = 3'b001;
    tick(1); chk("R3 not all ds -> standby; R4 clk-gate cycle", E_SB_CG);
    tick(1); chk("R5 standby domains; R11 code 01", E_SB);
    core_ds_req = 3'b111;
    tick(2); chk("R10 ds flags in standby ignored", E_SB);
    core_wfi = 3'b101;
    tick(1); chk("R6 wfi drop exits next edge; R8 power first", E_SB_CG);
    for (int k = 1; k < int'(s); k++) begin
      tick(1); chk("R8 clocks held during settle", E_SB_CG);
    end
    tick(1); chk("R8 clocks back after settle", E_ACT);
    idle_inputs(); tick(1);
  endtask

  task automatic t_standby_wake_line();
    settle_cyc = 4'd2;
    core_wfi = 3'b111;
    tick(2); chk("R2 all wfi -> standby", E_SB);
    per_wake = 4'b0010;
    tick(1); chk("R12 sync stage 1 no effect", E_SB);
    tick(1); chk("R12 sync stage 2 no effect", E_SB);
    tick(1); chk("R6 wake line exits on third edge", E_SB_CG);
    core_wfi = 3'b000; per_wake = 4'h0;
    tick(2); chk("R8 standby wake settle 2", E_ACT);
  endtask

  task automatic t_deep_rtc();
    settle_cyc = 4'd3;
    core_wfi = 3'b111; core_ds_req = 3'b111;
    tick(1); chk("R4 deep clk-gate cycle, power held", E_DS_CG);
    tick(1); chk("R5 deep domains; R11 code 10", E_DS);
    core_wfi = 3'b000; core_ds_req = 3'b000;
    tick(2); chk("R7 core flags ignored in deep", E_DS);
    per_wake = 4'b1010;
    tick(4); chk("R7 non-retained wake ignored", E_DS);
    per_wake = 4'h0; tick(1);
    rtc_wake = 1'b1;
    tick(2); chk("R12 rtc not yet through sync", E_DS);
    tick(1); chk("R7 rtc wake; R8 power restored first", E_DS_CG);
    tick(2); chk("R8 deep settle clocks off", E_DS_CG);
    tick(1); chk("R8 deep clocks back after 3", E_ACT);
    rtc_wake = 1'b0; tick(1);
  endtask

  task automatic t_deep_periph();
    settle_cyc = 4'd0;
    core_wfi = 3'b111; core_ds_req = 3'b111;
    tick(2); chk("R3 all flags -> deep", E_DS);
    core_wfi = 3'b000; core_ds_req = 3'b000;
    per_wake = 4'b0100;
    tick(3); chk("R7 retained slice wakes deep", E_DS_CG);
    tick(1); chk("R8 settle 0 acts as 1", E_ACT);
    per_wake = 4'h0; tick(1);
  endtask

  task automatic t_abort();
    core_wfi = 3'b111;
    tick(1); chk("R9 sb clk-gate", E_SB_CG);
    core_wfi = 3'b101;
    tick(1); chk("R9 sb abort to active", E_ACT);
    tick(1); chk("R9 sb abort no power drop", E_ACT);
    core_wfi = 3'b111; core_ds_req = 3'b111;
    tick(1); chk("R9 ds clk-gate", E_DS_CG);
    core_ds_req = 3'b110;
    tick(1); chk("R9 ds abort on flag drop", E_ACT);
    idle_inputs(); tick(1);
  endtask

  task automatic t_active_ignore();
    rtc_wake = 1'b1; per_wake = 4'hF;
    for (int k = 0; k < 5; k++) begin
      tick(1); chk("R12 wake ignored in active", E_ACT);
    end
    idle_inputs(); tick(3);
    chk("R12 active after wake lines clear", E_ACT);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_partial_wfi();
        t_standby(4'd3);
        t_standby(4'd1);
        t_standby_wake_line();
        t_deep_rtc();
        t_deep_periph();
        t_abort();
        t_active_ignore();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule